// File: doc/BRIEF.md
# Sloped Check-Wave Scheduler for a Two-Dimensional Mesh

This block decides, cycle by cycle, which processing elements of a ROWS x COLS mesh run their work under concurrent error checking. Data in the mesh moves rightward and downward. Every element follows the same repeating schedule of `period_m` cycles. The first `dur_n` phases of each period are checked and the remaining phases are unchecked. Elements differ only in where they start inside that period.

Each element's starting phase depends on its row, its column and two slope controls, `rise` and `run`. Together these make the checked cycles sweep across the mesh as diagonal waves. The waves travel against the data flow, so they meet errors that are moving downstream.

A one-cycle `start` pulse does two things. It captures the period and the checked length, and it computes every element's offset from the live inputs. The offsets are then held in per-element registers and exported beside the enable bits. Each element's phase counter begins at its offset and advances once per cycle, wrapping at the period.

Top module: `wave_sched_top`

## Requirements
- R1: After reset and until the first `start`, every bit of `chk_en` and every bit of `pe_offset` is 0.
- R2: In the cycle after `start`, the element at row i, column j reports offset ((Me + i + j - (ROWS-1-i)*run - (COLS-1-j)*rise) mod Me) on `pe_offset`, as a value in 0..Me-1. Me is the captured period. Example: on a 10x10 mesh with period 10, rise 2 and run 1, this is (2i+3j-17) mod 10.
- R3: Each element's phase equals its offset in the cycle after `start`, and then rises by one per cycle, returning to 0 after Me-1.
- R4: `chk_en` for an element is 1 exactly while its phase is below the captured `dur_n`. So over any Me consecutive cycles it is 1 for min(`dur_n`, Me) cycles.
- R5: Changes to `period_m`, `dur_n`, `rise` or `run` without a `start` have no effect on `chk_en` or `pe_offset`.
- R6: A `start` while running recomputes all offsets from the new inputs and restarts every phase at its new offset in the next cycle.
- R7: If the captured `dur_n` is at least Me, every enable stays at 1. If it is 0, every enable stays at 0.
- R8: A `period_m` of 0 at `start` is captured as a period of 1. In that case all offsets are 0 and every phase stays 0.
- R9: The element at row i, column j uses bit i*COLS+j of `chk_en` and bits [MW*(i*COLS+j) +: MW] of `pe_offset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Captures the parameters, computes the offsets and restarts the phases |
| period_m | input | MW | Schedule period in cycles (0 is taken as 1) |
| dur_n | input | MW | Number of checked phases per period |
| rise | input | MW | Column slope weight |
| run | input | MW | Row slope weight |
| chk_en | output | ROWS*COLS | Per-element check enable |
| pe_offset | output | ROWS*COLS*MW | Per-element captured offset |

## Verification
The bench builds the block as a 10x10 mesh with a 6-bit parameter width. This size makes the two closed-form offset patterns reachable: (2i+3j-17) mod 10 and (2i+4j-23) mod 13. It also lets sums go strongly negative at the top-left corner, so the modulo wrap is tested. A behavioural model of all 100 phase counters is compared against both outputs on every cycle. The runs cover a mid-run parameter change, a restart, saturated and empty checked lengths, and a zero period.

// File: rtl/wave_pkg.sv
package wave_pkg;
    // Non-negative remainder of a signed value; b must be positive.
    function automatic int floor_mod(input int a, input int b);
        int r;
        r = a % b;
        if (r < 0) r = r + b;
        return r;
    endfunction
endpackage

// File: rtl/wave_offset_calc.sv
module wave_offset_calc #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int MW   = 6,
    parameter int ROW  = 0,
    parameter int COL  = 0
) (
    input  logic [MW-1:0] m_i,
    input  logic [MW-1:0] rise_i,
    input  logic [MW-1:0] run_i,
    output logic [MW-1:0] off_o
);
    import wave_pkg::*;

    localparam int ROW_W = ROWS - 1 - ROW;
    localparam int COL_W = COLS - 1 - COL;

    int sum_d;
    int rem_d;

    always_comb begin
        sum_d = int'(m_i) + ROW + COL - ROW_W * int'(run_i) - COL_W * int'(rise_i);
        rem_d = floor_mod(sum_d, int'(m_i));
        off_o = rem_d[MW-1:0];
    end
endmodule

// File: rtl/wave_pe_phase.sv
module wave_pe_phase #(
    parameter int MW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          active_i,
    input  logic [MW-1:0] off_i,
    input  logic [MW-1:0] m_i,
    input  logic [MW-1:0] n_i,
    output logic [MW-1:0] off_o,
    output logic          en_o
);
    typedef struct packed {
        logic [MW-1:0] off;
        logic [MW-1:0] phase;
    } pe_st_t;

    pe_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.off   = off_i;
            st_d.phase = off_i;
        end else if (active_i) begin
            if (st_q.phase + 1'b1 >= m_i) st_d.phase = '0;
            else                          st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign off_o = st_q.off;
    assign en_o  = active_i && (st_q.phase < n_i);

    AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> (st_q.off < m_i)); // R2

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !load_i) |=> (load_i || st_q.phase ==
            ((($past(st_q.phase) + 1'b1) >= m_i) ? '0 : $past(st_q.phase) + 1'b1))); // R3
endmodule

// File: rtl/wave_sched_top.sv
module wave_sched_top #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int MW   = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [MW-1:0]          period_m,
    input  logic [MW-1:0]          dur_n,
    input  logic [MW-1:0]          rise,
    input  logic [MW-1:0]          run,
    output logic [ROWS*COLS-1:0]   chk_en,
    output logic [ROWS*COLS*MW-1:0] pe_offset
);
    localparam int NPE = ROWS * COLS;

    typedef struct packed {
        logic          active;
        logic [MW-1:0] m;
        logic [MW-1:0] n;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;
    logic [MW-1:0] m_eff;

    assign m_eff = (period_m == '0) ? MW'(1) : period_m;

    always_comb begin
        ctl_d = ctl_q;
        if (start) begin
            ctl_d.active = 1'b1;
            ctl_d.m      = m_eff;
            ctl_d.n      = dur_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.active <= 1'b0;
            ctl_q.m      <= MW'(1);
            ctl_q.n      <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int IDX = r * COLS + c;
            logic [MW-1:0] off_new;

            wave_offset_calc #(
                .ROWS(ROWS), .COLS(COLS), .MW(MW), .ROW(r), .COL(c)
            ) u_off (
                .m_i    (m_eff),
                .rise_i (rise),
                .run_i  (run),
                .off_o  (off_new)
            );

            wave_pe_phase #(.MW(MW)) u_pe (
                .clk      (clk),
                .rst_n    (rst_n),
                .load_i   (start),
                .active_i (ctl_q.active),
                .off_i    (off_new),
                .m_i      (ctl_q.m),
                .n_i      (ctl_q.n),
                .off_o    (pe_offset[IDX*MW +: MW]),
                .en_o     (chk_en[IDX])
            );
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.active |-> (chk_en == '0)); // R1

    AST_PARAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.active && !start) |=> ($stable(ctl_q.m) && $stable(ctl_q.n))); // R5

    AST_FULL_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.active && ctl_q.n >= ctl_q.m) |-> (&chk_en)); // R7

    AST_NO_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.active && ctl_q.n == '0) |-> (chk_en == '0)); // R7

    AST_UNIT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.active && ctl_q.m == MW'(1)) |-> (pe_offset == '0)); // R8

    initial assert (NPE > 0);
endmodule

// File: tb/tb_wave_sched_top.sv
module tb_wave_sched_top;
    localparam int CLK_P = 10;
    localparam int R = 10;
    localparam int C = 10;
    localparam int W = 6;
    localparam int NP = R * C;

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0;
    logic [W-1:0] period_m = 0, dur_n = 0, rise = 0, run = 0;
    logic [NP-1:0] chk_en;
    logic [NP*W-1:0] pe_offset;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int ref_off [NP];
    int ref_ph [NP];
    int ref_m = 1, ref_n = 0;
    bit ref_act = 0;
    bit live_cmp = 0;

    wave_sched_top #(.ROWS(R), .COLS(C), .MW(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .period_m(period_m),
        .dur_n(dur_n), .rise(rise), .run(run), .chk_en(chk_en), .pe_offset(pe_offset)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int get_off(input int i, input int j);
        return int'(pe_offset[(i*C+j)*W +: W]);
    endfunction

    function automatic int pos_mod(input int s, input int m);
        while (s < 0) s += m;
        return s % m;
    endfunction

    // Behavioural model of every element
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_act = 0; ref_m = 1; ref_n = 0;
            for (int k = 0; k < NP; k++) begin ref_off[k] = 0; ref_ph[k] = 0; end
        end else if (start) begin
            ref_m = (period_m == 0) ? 1 : int'(period_m);
            ref_n = int'(dur_n);
            ref_act = 1;
            for (int i = 0; i < R; i++)
                for (int j = 0; j < C; j++) begin
                    ref_off[i*C+j] = pos_mod(ref_m + i + j - (R-1-i)*int'(run)
                                             - (C-1-j)*int'(rise), ref_m);
                    ref_ph[i*C+j] = ref_off[i*C+j];
                end
        end else if (ref_act) begin
            for (int k = 0; k < NP; k++) ref_ph[k] = (ref_ph[k] + 1) % ref_m;
        end
    end

    // Cycle-by-cycle comparison
    always @(negedge clk) begin
        if (live_cmp && !done) begin
            logic [NP-1:0] exp_en;
            bit off_ok;
            off_ok = 1;
            for (int k = 0; k < NP; k++) begin
                exp_en[k] = ref_act && (ref_ph[k] < ref_n);
                if (int'(pe_offset[k*W +: W]) != ref_off[k]) off_ok = 0;
            end
            check(chk_en == exp_en, "R3/R4 enable vector", 0, 0);
            if (chk_en != exp_en)
                $display("  detail: enables actual=%h expected=%h", chk_en, exp_en);
            check(off_ok, "R2 offsets vs model", 0, 0);
        end
    end

    task automatic go(input int m, input int n, input int ri, input int ru);
        @(negedge clk);
        period_m = W'(m); dur_n = W'(n); rise = W'(ri); run = W'(ru); start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    int cnt;
    logic [NP*W-1:0] snap_off;

    initial begin
        wait_cyc(3);
        rst_n = 1;
        wait_cyc(3);
        // R1: quiet before start
        check(chk_en == '0, "R1 enables idle", chk_en, 0);
        check(pe_offset == '0, "R1 offsets idle", 0, 0);
        live_cmp = 1;

        // R2: closed form for period 10, rise 2, run 1
        go(10, 3, 2, 1);
        for (int i = 0; i < R; i++)
            for (int j = 0; j < C; j++)
                check(get_off(i, j) == pos_mod(2*i + 3*j - 17, 10), "R2 offset 2i+3j-17",
                      get_off(i, j), pos_mod(2*i + 3*j - 17, 10));
        // R9: layout of specific elements
        check(int'(pe_offset[1*W +: W]) == 6, "R9 element (0,1)", pe_offset[1*W +: W], 6);
        check(int'(pe_offset[99*W +: W]) == 8, "R9 element (9,9)", pe_offset[99*W +: W], 8);
        // R4: three checked cycles out of ten for element 0
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            if (chk_en[0]) cnt++;
            wait_cyc(1);
        end
        check(cnt == 3, "R4 checked count per period", cnt, 3);
        wait_cyc(7);

        // R5: input changes without start
        snap_off = pe_offset;
        @(negedge clk);
        period_m = 7; dur_n = 1; rise = 5; run = 4;
        wait_cyc(20);
        check(pe_offset == snap_off, "R5 offsets unchanged", 0, 0);

        // R6: restart with period 13, rise 3, run 1
        go(13, 5, 3, 1);
        for (int i = 0; i < R; i++)
            for (int j = 0; j < C; j++)
                check(get_off(i, j) == pos_mod(2*i + 4*j - 23, 13), "R6 offset 2i+4j-23",
                      get_off(i, j), pos_mod(2*i + 4*j - 23, 13));
        wait_cyc(30);

        // R7: saturated and empty checked lengths
        go(4, 7, 1, 2);
        wait_cyc(1);
        for (int k = 0; k < 6; k++) begin
            check(&chk_en, "R7 all enabled", chk_en, 0);
            wait_cyc(1);
        end
        go(9, 0, 2, 3);
        for (int k = 0; k < 6; k++) begin
            check(chk_en == '0, "R7 none enabled", chk_en, 0);
            wait_cyc(1);
        end

        // R8: zero period acts as period one
        go(0, 1, 3, 5);
        for (int k = 0; k < 4; k++) begin
            check(pe_offset == '0, "R8 offsets zero", 0, 0);
            check(&chk_en, "R8 enables with n=1", chk_en, 0);
            wait_cyc(1);
        end

        // Random-ish further patterns through the model
        go(31, 11, 7, 5);
        wait_cyc(40);
        go(63, 20, 0, 0);
        wait_cyc(70);

        live_cmp = 0;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule